// File: doc/BRIEF.md
# Interrupt and Trap Sequencer

This block sits beside an instruction-execution unit and is consulted at every instruction boundary. When the execution unit signals a boundary, the sequencer decides whether a software-programmed priority request, an external device request or nothing is to be serviced. It reads the current processor priority from the status word and scans the request levels from the top down. When the execution unit reports a fault (a bus error or an illegal instruction), the sequencer takes a trap ahead of any interrupt.

Once a trap or interrupt is chosen, the sequencer drives a word-wide memory port through a fixed four-access sequence. It first fetches the new status word from the vector slot plus two. It then pushes the old status, then the old program counter, onto the stack, with a pre-decrement before each push. Last, it fetches the new program counter from the vector slot. In a single commit cycle it then hands the new program counter, status word and stack pointer back to the core and acknowledges the device that was served. Bus-error cause flags build up in a sticky error register. A boundary taken in the wait state either wakes the processor (interrupt taken) or does nothing. A halted processor suppresses every decision.

Top module: `trap_sequencer`

## Requirements
- R1: Request levels are scanned from 7 downward, and the first pending level wins. At the same level, a programmed request is taken before a device request.
- R2: A programmed request at level i is pending when bit 8+i of `sw_req_i` is set. It traps through vector 0x00A0. Bits 8 (level 0) and 7..0 never cause a trap.
- R3: A device request at level i is `dev_req_i[i]`, with its vector at `dev_vec_i[16*i +: 16]`. `dev_ack_o[i]` is high only in the commit cycle of that trap, and at most one ack bit is high at a time.
- R4: Only levels strictly above the current priority (`psw_i` bits 7..5) are taken. A request at or below it is left pending, and the boundary executes instead.
- R5: A trap through vector V with stack pointer S makes exactly four accesses in this order: read V+2, write the old status to S-2, write the old PC to S-4, read V.
- R6: One cycle after the last access, `load_o` is high for one cycle with `new_pc_o` = word read from V, `new_psw_o` = word read from V+2 and `new_sp_o` = S-4. The block is idle in the next cycle.
- R7: In the running state (`run_state_i` = 1) with nothing taken, `exec_o` pulses in the cycle after `step_i`, and no memory access is made.
- R8: In the wait state (`run_state_i` = 2), a taken interrupt pulses `wake_o` in the cycle after `step_i` and starts the trap. With nothing taken, neither `exec_o` nor `wake_o` pulses and no access is made.
- R9: A non-zero `bus_fault_i` traps through vector 0x0004 and ORs cause bits into `cpu_err_o`: bus_fault_i[0] (odd address) sets 0x0040, [1] (non-existent memory) sets 0x0020, [2] (timeout) sets 0x0010. The bits never clear. A fault is taken ahead of a `step_i` in the same cycle, and that step is dropped.
- R10: `illegal_i` traps through vector 0x0010 and leaves `cpu_err_o` unchanged. A bus fault in the same cycle wins.
- R11: With `run_state_i` = 0 (halted), step and fault inputs are ignored: no access, no pulse and no error-register change.
- R12: While a sequence is in progress, new step and fault inputs are ignored. An access is held with a stable address until `mem_ack_i`.
- R13: After reset the block is idle, has no bus request, no pulse or ack, and `cpu_err_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_state_i | input | 2 | 0 halted, 1 running, 2 waiting for interrupt |
| step_i | input | 1 | Instruction boundary strobe |
| bus_fault_i | input | 3 | Bus fault cause strobe: odd address, non-existent memory, timeout |
| illegal_i | input | 1 | Illegal instruction strobe |
| psw_i | input | 16 | Current status word, priority in bits 7..5 |
| sw_req_i | input | 16 | Programmed interrupt request register |
| dev_req_i | input | 8 | Device request per level |
| dev_vec_i | input | 128 | Device vector per level, 16 bits each |
| pc_i | input | 16 | Current program counter |
| sp_i | input | 16 | Current stack pointer |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 16 | Access address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid with ack |
| mem_ack_i | input | 1 | Access completes |
| busy_o | output | 1 | Sequence in progress |
| exec_o | output | 1 | Execute the next instruction |
| wake_o | output | 1 | Leave the wait state |
| load_o | output | 1 | Commit new PC, status and stack pointer |
| new_pc_o | output | 16 | New program counter |
| new_psw_o | output | 16 | New status word |
| new_sp_o | output | 16 | New stack pointer |
| dev_ack_o | output | 8 | Device acknowledge, one-hot by level |
| cpu_err_o | output | 16 | Sticky bus-error cause register |

## Verification
Arbitration is tried with requests at several levels at once, with a programmed request and a device request tied at one level, and with requests at, below and above the current priority. These patterns separate a correct top-down scan from one that is upward, inclusive of the current priority, or biased toward the device side. Faults are raised alone, together with a pending interrupt, and combined with an illegal instruction, to show the fixed ordering among the sources and the sticky build-up of cause bits. The access sequence runs with zero and with several wait states, and extra strobes are injected mid-sequence, so that the order of accesses, the held addresses and the ignoring of a busy block are each seen on the memory port.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

    localparam int WORD_W = 16;
    localparam int LEVELS = 8;
    localparam int PRIO_W = 3;
    localparam int FLAG_W = 3;

    // fault cause flag positions on the bus_fault input
    localparam int FLAG_ODD = 0;
    localparam int FLAG_NXM = 1;
    localparam int FLAG_TMO = 2;

    typedef enum logic [1:0] {
        RS_HALT = 2'd0,
        RS_RUN  = 2'd1,
        RS_WAIT = 2'd2
    } run_state_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GET_PSW,
        ST_PUSH_PSW,
        ST_PUSH_PC,
        ST_GET_PC,
        ST_COMMIT
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_SOFT,
        SRC_DEV,
        SRC_FAULT
    } src_e;

    typedef struct packed {
        logic              hit;
        src_e              src;
        logic [PRIO_W-1:0] level;
        logic [WORD_W-1:0] vector;
    } grant_t;

    function automatic logic [LEVELS-1:0] level_onehot(input logic [PRIO_W-1:0] lv);
        logic [LEVELS-1:0] oh;
        oh     = '0;
        oh[lv] = 1'b1;
        return oh;
    endfunction

endpackage

// File: rtl/trap_irq_arbiter.sv
module trap_irq_arbiter
    import trap_seq_pkg::*;
#(
    parameter int                SOFT_BASE = 8,
    parameter int                PRIO_LSB  = 5,
    parameter logic [WORD_W-1:0] VEC_SOFT  = 16'h00A0
) (
    input  logic [WORD_W-1:0]        psw_i,
    input  logic [WORD_W-1:0]        sw_req_i,
    input  logic [LEVELS-1:0]        dev_req_i,
    input  logic [LEVELS*WORD_W-1:0] dev_vec_i,
    output grant_t                   grant_o
);

    logic [PRIO_W-1:0] cur_prio;
    logic              unused_inputs;

    assign cur_prio      = psw_i[PRIO_LSB +: PRIO_W];
    // level 0 and the non-level bits are never examined
    assign unused_inputs = ^{psw_i, sw_req_i, dev_req_i, dev_vec_i};

    // top-down scan; at a given level the programmed request goes first
    always_comb begin
        grant_o = '0;
        for (int lv = LEVELS - 1; lv >= 1; lv--) begin
            if (!grant_o.hit && (lv > int'(cur_prio))) begin
                if (sw_req_i[SOFT_BASE + lv]) begin
                    grant_o.hit    = 1'b1;
                    grant_o.src    = SRC_SOFT;
                    grant_o.level  = PRIO_W'(lv);
                    grant_o.vector = VEC_SOFT;
                end else if (dev_req_i[lv]) begin
                    grant_o.hit    = 1'b1;
                    grant_o.src    = SRC_DEV;
                    grant_o.level  = PRIO_W'(lv);
                    grant_o.vector = dev_vec_i[lv*WORD_W +: WORD_W];
                end
            end
        end
    end

endmodule

// File: rtl/trap_fault_log.sv
module trap_fault_log
    import trap_seq_pkg::*;
#(
    parameter int ODD_BIT = 6,
    parameter int NXM_BIT = 5,
    parameter int TMO_BIT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [WORD_W-1:0] err_o
);

    // cause bits are sticky: they are only ever set
    always_ff @(posedge clk) begin
        if (rst) begin
            err_o <= '0;
        end else if (take_i) begin
            if (flags_i[FLAG_ODD]) err_o[ODD_BIT] <= 1'b1;
            if (flags_i[FLAG_NXM]) err_o[NXM_BIT] <= 1'b1;
            if (flags_i[FLAG_TMO]) err_o[TMO_BIT] <= 1'b1;
        end
    end

endmodule

// File: rtl/trap_vector_fsm.sv
module trap_vector_fsm
    import trap_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [WORD_W-1:0] vec_i,
    input  src_e              src_i,
    input  logic [PRIO_W-1:0] level_i,
    input  logic [WORD_W-1:0] psw_i,
    input  logic [WORD_W-1:0] pc_i,
    input  logic [WORD_W-1:0] sp_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    input  logic              mem_ack_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [WORD_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    output logic              busy_o,
    output logic              load_o,
    output logic [WORD_W-1:0] new_pc_o,
    output logic [WORD_W-1:0] new_psw_o,
    output logic [WORD_W-1:0] new_sp_o,
    output logic [LEVELS-1:0] dev_ack_o
);

    localparam logic [WORD_W-1:0] STEP_ONE = WORD_W'(2);
    localparam logic [WORD_W-1:0] STEP_TWO = WORD_W'(4);

    seq_state_e        state;
    src_e              src_r;
    logic [PRIO_W-1:0] lvl_r;
    logic [WORD_W-1:0] vec_r;
    logic [WORD_W-1:0] old_psw_r;
    logic [WORD_W-1:0] old_pc_r;
    logic [WORD_W-1:0] sp_r;
    logic [WORD_W-1:0] psw_r;
    logic [WORD_W-1:0] pc_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            src_r     <= SRC_NONE;
            lvl_r     <= '0;
            vec_r     <= '0;
            old_psw_r <= '0;
            old_pc_r  <= '0;
            sp_r      <= '0;
            psw_r     <= '0;
            pc_r      <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        vec_r     <= vec_i;
                        src_r     <= src_i;
                        lvl_r     <= level_i;
                        old_psw_r <= psw_i;
                        old_pc_r  <= pc_i;
                        sp_r      <= sp_i;
                        state     <= ST_GET_PSW;
                    end
                end
                ST_GET_PSW: begin
                    if (mem_ack_i) begin
                        psw_r <= mem_rdata_i;
                        state <= ST_PUSH_PSW;
                    end
                end
                ST_PUSH_PSW: begin
                    if (mem_ack_i) state <= ST_PUSH_PC;
                end
                ST_PUSH_PC: begin
                    if (mem_ack_i) state <= ST_GET_PC;
                end
                ST_GET_PC: begin
                    if (mem_ack_i) begin
                        pc_r  <= mem_rdata_i;
                        state <= ST_COMMIT;
                    end
                end
                ST_COMMIT: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        unique case (state)
            ST_GET_PSW: begin
                mem_req_o  = 1'b1;
                mem_addr_o = vec_r + STEP_ONE;
            end
            ST_PUSH_PSW: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = sp_r - STEP_ONE;
                mem_wdata_o = old_psw_r;
            end
            ST_PUSH_PC: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = sp_r - STEP_TWO;
                mem_wdata_o = old_pc_r;
            end
            ST_GET_PC: begin
                mem_req_o  = 1'b1;
                mem_addr_o = vec_r;
            end
            default: ;
        endcase
    end

    assign busy_o    = (state != ST_IDLE);
    assign load_o    = (state == ST_COMMIT);
    assign new_pc_o  = pc_r;
    assign new_psw_o = psw_r;
    assign new_sp_o  = sp_r - STEP_TWO;
    assign dev_ack_o = (load_o && (src_r == SRC_DEV)) ? level_onehot(lvl_r) : '0;

endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
    import trap_seq_pkg::*;
#(
    parameter int                SOFT_BASE   = 8,
    parameter int                PRIO_LSB    = 5,
    parameter logic [WORD_W-1:0] VEC_SOFT    = 16'h00A0,
    parameter logic [WORD_W-1:0] VEC_BUS     = 16'h0004,
    parameter logic [WORD_W-1:0] VEC_ILLEGAL = 16'h0010,
    parameter int                ERR_ODD_BIT = 6,
    parameter int                ERR_NXM_BIT = 5,
    parameter int                ERR_TMO_BIT = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [1:0]               run_state_i,
    input  logic                     step_i,
    input  logic [FLAG_W-1:0]        bus_fault_i,
    input  logic                     illegal_i,
    input  logic [WORD_W-1:0]        psw_i,
    input  logic [WORD_W-1:0]        sw_req_i,
    input  logic [LEVELS-1:0]        dev_req_i,
    input  logic [LEVELS*WORD_W-1:0] dev_vec_i,
    input  logic [WORD_W-1:0]        pc_i,
    input  logic [WORD_W-1:0]        sp_i,
    output logic                     mem_req_o,
    output logic                     mem_we_o,
    output logic [WORD_W-1:0]        mem_addr_o,
    output logic [WORD_W-1:0]        mem_wdata_o,
    input  logic [WORD_W-1:0]        mem_rdata_i,
    input  logic                     mem_ack_i,
    output logic                     busy_o,
    output logic                     exec_o,
    output logic                     wake_o,
    output logic                     load_o,
    output logic [WORD_W-1:0]        new_pc_o,
    output logic [WORD_W-1:0]        new_psw_o,
    output logic [WORD_W-1:0]        new_sp_o,
    output logic [LEVELS-1:0]        dev_ack_o,
    output logic [WORD_W-1:0]        cpu_err_o
);

    run_state_e        rs;
    grant_t            grant;
    logic              active;
    logic              bus_hit;
    logic              take_fault;
    logic              take_irq;
    logic              start;
    logic [WORD_W-1:0] start_vec;
    src_e              start_src;
    logic              exec_q;
    logic              wake_q;

    assign rs = run_state_e'(run_state_i);

    trap_irq_arbiter #(
        .SOFT_BASE (SOFT_BASE),
        .PRIO_LSB  (PRIO_LSB),
        .VEC_SOFT  (VEC_SOFT)
    ) u_arb (
        .psw_i     (psw_i),
        .sw_req_i  (sw_req_i),
        .dev_req_i (dev_req_i),
        .dev_vec_i (dev_vec_i),
        .grant_o   (grant)
    );

    // decision at the boundary: faults first, then the arbiter's grant
    assign active     = !busy_o && (rs != RS_HALT);
    assign bus_hit    = |bus_fault_i;
    assign take_fault = active && (bus_hit || illegal_i);
    assign take_irq   = active && !take_fault && step_i && grant.hit;
    assign start      = take_fault || take_irq;
    assign start_src  = take_fault ? SRC_FAULT : grant.src;

    always_comb begin
        if (take_fault) start_vec = bus_hit ? VEC_BUS : VEC_ILLEGAL;
        else            start_vec = grant.vector;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            exec_q <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            exec_q <= active && !take_fault && step_i && !grant.hit && (rs == RS_RUN);
            wake_q <= take_irq && (rs == RS_WAIT);
        end
    end

    assign exec_o = exec_q;
    assign wake_o = wake_q;

    trap_fault_log #(
        .ODD_BIT (ERR_ODD_BIT),
        .NXM_BIT (ERR_NXM_BIT),
        .TMO_BIT (ERR_TMO_BIT)
    ) u_log (
        .clk     (clk),
        .rst     (rst),
        .take_i  (take_fault && bus_hit),
        .flags_i (bus_fault_i),
        .err_o   (cpu_err_o)
    );

    trap_vector_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .vec_i       (start_vec),
        .src_i       (start_src),
        .level_i     (grant.level),
        .psw_i       (psw_i),
        .pc_i        (pc_i),
        .sp_i        (sp_i),
        .mem_rdata_i (mem_rdata_i),
        .mem_ack_i   (mem_ack_i),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .busy_o      (busy_o),
        .load_o      (load_o),
        .new_pc_o    (new_pc_o),
        .new_psw_o   (new_psw_o),
        .new_sp_o    (new_sp_o),
        .dev_ack_o   (dev_ack_o)
    );

endmodule

// File: rtl/trap_sequencer_checker.sv
module trap_sequencer_checker (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  run_state_i,
    input logic        busy_o,
    input logic        exec_o,
    input logic        wake_o,
    input logic        load_o,
    input logic        mem_req_o,
    input logic        mem_we_o,
    input logic [15:0] mem_addr_o,
    input logic        mem_ack_i,
    input logic [7:0]  dev_ack_o,
    input logic [15:0] cpu_err_o
);

    assert_bus_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

    assert_ack_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dev_ack_o));

    assert_ack_commit_R3: assert property (@(posedge clk) disable iff (rst)
        (|dev_ack_o) |-> load_o);

    assert_halt_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && run_state_i == 2'd0) |=> (!busy_o && !exec_o && !wake_o));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(cpu_err_o) & ~cpu_err_o) == 16'h0000));

    assert_exec_idle_R7: assert property (@(posedge clk) disable iff (rst)
        exec_o |-> (!busy_o && !wake_o && !mem_req_o));

    assert_commit_end_R6: assert property (@(posedge clk) disable iff (rst)
        load_o |=> !busy_o);

    assert_write_req_R5: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> mem_req_o);

    assert_wait_noexec_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && run_state_i == 2'd2) |=> !exec_o);

endmodule

bind trap_sequencer trap_sequencer_checker u_checker (
    .clk         (clk),
    .rst         (rst),
    .run_state_i (run_state_i),
    .busy_o      (busy_o),
    .exec_o      (exec_o),
    .wake_o      (wake_o),
    .load_o      (load_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ack_i   (mem_ack_i),
    .dev_ack_o   (dev_ack_o),
    .cpu_err_o   (cpu_err_o)
);

// File: tb/tb_trap_sequencer.sv
`timescale 1ns/1ps
module tb_trap_sequencer;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   rs = 2'd1;
    logic         step = 1'b0;
    logic [2:0]   bfault = 3'b000;
    logic         ill = 1'b0;
    logic [15:0]  psw = 16'h0000;
    logic [15:0]  swreq = 16'h0000;
    logic [7:0]   devreq = 8'h00;
    logic [127:0] devvec = '0;
    logic [15:0]  pc = 16'h1000;
    logic [15:0]  sp = 16'h0800;
    logic [15:0]  mem_rdata = 16'h0000;
    logic         mem_ack = 1'b0;

    logic         mem_req, mem_we, busy, exec_p, wake_p, load_p;
    logic [15:0]  mem_addr, mem_wdata, new_pc, new_psw, new_sp, cpu_err;
    logic [7:0]   dev_ack;

    int n_checks = 0;
    int n_errors = 0;
    int lat = 0;
    int wcnt = 0;
    logic [15:0] hold_addr = 16'h0000;
    logic [15:0] exp_err = 16'h0000;

    logic [15:0] mem [logic [15:0]];

    typedef struct {
        bit          we;
        logic [15:0] a;
        logic [15:0] d;
    } acc_t;
    acc_t exp_q[$];

    always #10 clk = ~clk;

    trap_sequencer dut (
        .clk (clk), .rst (rst), .run_state_i (rs), .step_i (step),
        .bus_fault_i (bfault), .illegal_i (ill), .psw_i (psw), .sw_req_i (swreq),
        .dev_req_i (devreq), .dev_vec_i (devvec), .pc_i (pc), .sp_i (sp),
        .mem_req_o (mem_req), .mem_we_o (mem_we), .mem_addr_o (mem_addr),
        .mem_wdata_o (mem_wdata), .mem_rdata_i (mem_rdata), .mem_ack_i (mem_ack),
        .busy_o (busy), .exec_o (exec_p), .wake_o (wake_p), .load_o (load_p),
        .new_pc_o (new_pc), .new_psw_o (new_psw), .new_sp_o (new_sp),
        .dev_ack_o (dev_ack), .cpu_err_o (cpu_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // memory responder with a programmable number of wait states
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            wcnt    = 0;
        end else if (mem_req && !rst) begin
            if (wcnt == 0) hold_addr = mem_addr;
            if (wcnt >= lat) begin
                chk("R12 address held until ack", {16'h0, mem_addr}, {16'h0, hold_addr});
                if (exp_q.size() == 0) begin
                    chk("R11 unexpected access", 32'd1, 32'd0);
                end else begin
                    acc_t e;
                    e = exp_q.pop_front();
                    chk("R5 access direction", {31'h0, mem_we}, {31'h0, e.we});
                    chk("R5 access address", {16'h0, mem_addr}, {16'h0, e.a});
                    if (e.we) chk("R5 pushed data", {16'h0, mem_wdata}, {16'h0, e.d});
                end
                if (mem_we) mem[mem_addr] = mem_wdata;
                else        mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 16'h0000;
                mem_ack = 1'b1;
            end else begin
                wcnt++;
            end
        end
    end

    // behavioural reference: kind 0 none, 1 execute, 2 trap
    function automatic void predict(input bit st, input logic [2:0] f, input bit il,
                                    output int kind, output logic [15:0] vec,
                                    output int lvl, output bit irq);
        int prio;
        kind = 0; vec = 16'h0; lvl = -1; irq = 0;
        prio = int'(psw[7:5]);
        if (rs == 2'd0) return;
        if (f != 3'b000) begin kind = 2; vec = 16'h0004; return; end
        if (il) begin kind = 2; vec = 16'h0010; return; end
        if (!st) return;
        for (int i = 7; i > prio; i--) begin
            if (swreq[8 + i]) begin kind = 2; vec = 16'h00A0; irq = 1; return; end
            if (devreq[i]) begin kind = 2; vec = devvec[i*16 +: 16]; lvl = i; irq = 1; return; end
        end
        if (rs == 2'd1) kind = 1;
    endfunction

    function automatic logic [15:0] err_bits(input logic [2:0] f);
        return (f[0] ? 16'h0040 : 16'h0) | (f[1] ? 16'h0020 : 16'h0) | (f[2] ? 16'h0010 : 16'h0);
    endfunction

    task automatic do_event(input string req, input bit st, input logic [2:0] f,
                            input bit il, input bit poke);
        int kind, lvl;
        bit irq, seen;
        logic [15:0] vec, next_err;
        predict(st, f, il, kind, vec, lvl, irq);
        next_err = exp_err;
        if (rs != 2'd0 && f != 3'b000) next_err = exp_err | err_bits(f);
        if (kind == 2) begin
            mem[vec]           = vec ^ 16'h3C00;
            mem[vec + 16'd2]   = vec ^ 16'h00E0;
            exp_q.push_back('{we: 1'b0, a: vec + 16'd2, d: 16'h0});
            exp_q.push_back('{we: 1'b1, a: sp - 16'd2, d: psw});
            exp_q.push_back('{we: 1'b1, a: sp - 16'd4, d: pc});
            exp_q.push_back('{we: 1'b0, a: vec, d: 16'h0});
        end
        step = st; bfault = f; ill = il;
        @(negedge clk);
        step = 1'b0; bfault = 3'b000; ill = 1'b0;
        chk({req, " exec pulse"}, {31'h0, exec_p}, {31'h0, kind == 1});
        chk({req, " wake pulse"}, {31'h0, wake_p}, {31'h0, (kind == 2) && irq && (rs == 2'd2)});
        chk({req, " busy after decision"}, {31'h0, busy}, {31'h0, kind == 2});
        chk({req, " error register"}, {16'h0, cpu_err}, {16'h0, next_err});
        if (kind == 2) begin
            seen = 0;
            if (poke) begin
                repeat (2) @(negedge clk);
                step = 1'b1; bfault = 3'b100; ill = 1'b1;
                @(negedge clk);
                step = 1'b0; bfault = 3'b000; ill = 1'b0;
                @(negedge clk);
                chk("R12 strobe ignored while busy: exec", {31'h0, exec_p}, 32'd0);
                chk("R12 strobe ignored while busy: error register", {16'h0, cpu_err}, {16'h0, next_err});
            end
            for (int k = 0; k < 60 && !seen; k++) begin
                @(negedge clk);
                if (load_p) begin
                    seen = 1;
                    chk({req, " R6 new pc"}, {16'h0, new_pc}, {16'h0, vec ^ 16'h3C00});
                    chk({req, " R6 new status"}, {16'h0, new_psw}, {16'h0, vec ^ 16'h00E0});
                    chk({req, " R6 new stack pointer"}, {16'h0, new_sp}, {16'h0, sp - 16'd4});
                    chk({req, " R3 device ack"}, {24'h0, dev_ack},
                        {24'h0, (lvl >= 0) ? (8'h01 << lvl) : 8'h00});
                end
            end
            chk({req, " R6 commit seen"}, {31'h0, seen}, 32'd1);
            chk({req, " R5 all accesses made"}, exp_q.size(), 32'd0);
            @(negedge clk);
            chk({req, " R6 idle after commit"}, {31'h0, busy}, 32'd0);
        end else begin
            repeat (3) @(negedge clk);
            chk({req, " no sequence started"}, {31'h0, busy}, 32'd0);
        end
        exp_err = next_err;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) devvec[i*16 +: 16] = 16'h0100 + 16'(i * 8);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        chk("R13 busy after reset", {31'h0, busy}, 32'd0);
        chk("R13 bus request after reset", {31'h0, mem_req}, 32'd0);
        chk("R13 error register after reset", {16'h0, cpu_err}, 32'd0);
        chk("R13 pulses after reset", {29'h0, exec_p, wake_p, load_p}, 32'd0);
        chk("R13 device ack after reset", {24'h0, dev_ack}, 32'd0);

        // R7 running, nothing pending
        rs = 2'd1; psw = 16'h0000; swreq = 16'h0000; devreq = 8'h00;
        do_event("R7 running idle boundary", 1'b1, 3'b000, 1'b0, 1'b0);

        // R1 R2 two programmed levels, highest wins
        swreq = 16'h2800; pc = 16'h1234; sp = 16'h0800;
        do_event("R1 R2 programmed level 5 over 3", 1'b1, 3'b000, 1'b0, 1'b0);

        // R2 level 0 and low bits never trap
        swreq = 16'h01FF;
        do_event("R2 low bits ignored", 1'b1, 3'b000, 1'b0, 1'b0);

        // R1 tie at level 6: programmed first
        swreq = 16'h4000; devreq = 8'h40; pc = 16'h2222; sp = 16'h0700;
        do_event("R1 tie programmed first", 1'b1, 3'b000, 1'b0, 1'b0);

        // R3 device alone at level 6, plus lower device
        swreq = 16'h0000; devreq = 8'h44; pc = 16'h3330; sp = 16'h0600;
        do_event("R3 device level 6", 1'b1, 3'b000, 1'b0, 1'b0);

        // R4 at or below priority not taken
        psw = 16'h00A0; swreq = 16'h2000; devreq = 8'h10;
        do_event("R4 request at priority left pending", 1'b1, 3'b000, 1'b0, 1'b0);
        swreq = 16'h6000; pc = 16'h4444; sp = 16'h0500;
        do_event("R4 level above priority taken", 1'b1, 3'b000, 1'b0, 1'b0);

        // R8 wait state
        rs = 2'd2; psw = 16'h0000; swreq = 16'h0000; devreq = 8'h04; pc = 16'h5550;
        do_event("R8 wake on device level 2", 1'b1, 3'b000, 1'b0, 1'b0);
        devreq = 8'h00;
        do_event("R8 wait with nothing pending", 1'b1, 3'b000, 1'b0, 1'b0);

        // R9 bus faults, with a pending interrupt in the same cycle
        rs = 2'd1; swreq = 16'h8000; pc = 16'h6660; sp = 16'h0400;
        do_event("R9 non-existent memory fault over step", 1'b1, 3'b010, 1'b0, 1'b0);
        swreq = 16'h0000;
        do_event("R9 odd address fault", 1'b0, 3'b001, 1'b0, 1'b0);
        do_event("R9 timeout fault", 1'b0, 3'b100, 1'b0, 1'b0);

        // R10 illegal instruction, and bus fault beating it
        do_event("R10 illegal instruction", 1'b0, 3'b000, 1'b1, 1'b0);
        do_event("R10 bus fault beats illegal", 1'b0, 3'b001, 1'b1, 1'b0);

        // R11 halted
        rs = 2'd0; swreq = 16'h8000; devreq = 8'hFE;
        do_event("R11 halted step", 1'b1, 3'b000, 1'b0, 1'b0);
        do_event("R11 halted fault", 1'b0, 3'b110, 1'b1, 1'b0);

        // R12 wait states and strobes while busy
        rs = 2'd1; devreq = 8'h00; swreq = 16'h0800; lat = 3; pc = 16'h7770; sp = 16'h0300;
        do_event("R12 wait states with mid-sequence strobes", 1'b1, 3'b000, 1'b0, 1'b1);
        lat = 0;

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #3000000;
        n_checks++;
        n_errors++;
        $display("FAIL R12 watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule